// File: doc/BRIEF.md
# Two-Port Byte Mover and Pattern Finder

The block moves bytes between two address ports, A and B, one byte at a time, acting as master on a simple memory/IO bus. Each port keeps a 16-bit address and a small mode byte. The mode byte chooses I/O or memory space and sets the address to count up, count down or stay fixed. A direction bit picks which port is read and which is written. For every byte the engine reads from the source. When searching is enabled it compares the byte against a match value, with a mask marking the bits to ignore. When writing is enabled it stores the byte at the destination. It then counts the byte against a programmed block length.

Software loads eight configuration registers through a register-load port while the engine is idle, then pulses `start`. In continuous mode the engine loops until a match or the end of the block. In single-step mode it moves one byte per `start`. When it stops, it can raise an interrupt whose vector may carry a two-bit status code. While the engine is busy, register loads are ignored.

Register selects on `cfg_sel` are as follows. 0 is control: bit 0 enables writing, bit 1 enables search, bit 2 set makes A the source (clear makes B the source), bit 3 selects continuous mode. Writing control also clears the byte counter, the flags and the interrupt, and re-arms first-byte handling. 1 and 3 load the A and B addresses. 2 and 4 load the A and B mode bytes: bit 3 selects I/O, bit 5 holds the address fixed, and bit 4 chooses increment (1) or decrement (0). 5 loads the block length. 6 loads the match value in bits 7:0 and the ignore mask in bits 15:8. 7 is interrupt control: base vector in bits 7:0, bit 8 raises on match, bit 9 raises on end, bit 10 enables the interrupt, bit 13 puts the status code in the vector.

Top module: `dma2p_engine`

## Requirements
- R1: With control bit 2 set, reads use port A and writes use port B. With it clear, reads use B and writes use A.
- R2: Control bit 0 enables the write access of each byte. With it clear, no write cycle is issued.
- R3: With control bit 1 set, a byte where ((data XOR match) AND NOT mask) is zero sets `match_flag`. The run stops after that byte has been written and counted.
- R4: A port with mode bit 5 set keeps its address. Otherwise the address steps by +1 (bit 4 set) or -1 (bit 4 clear). Mode bit 3 drives `bus_io` for that port's accesses.
- R5: The first byte after a control write is read at the loaded addresses without stepping. Every later byte first steps both ports, then reads.
- R6: With length L nonzero, the block ends after L+1 bytes. With L zero, it ends only when the LW-bit byte counter wraps, after 2^LW bytes. The end sets `end_flag`.
- R7: Control bit 3 set runs bytes back to back until a stop. Clear moves one byte per `start`. A `start` is ignored once `end_flag` or `match_flag` is set.
- R8: With `bus_ready` held high, successive byte reads are exactly BYTE_CYC (6) cycles apart.
- R9: While `bus_rd` or `bus_wr` waits for `bus_ready`, the strobe, address, `bus_io` and write data stay stable.
- R10: On a stop with interrupts enabled, `irq` rises when the stop was a match and raise-on-match is set, or when it was end of block and raise-on-end is set. Otherwise `irq` stays low.
- R11: With bit 13 of interrupt control set, `irq_vec` bits 2:1 read 01 after a match and 10 after end of block (match wins). The other bits come from the base vector. With bit 13 clear, `irq_vec` equals the base vector.
- R12: `busy` is high from an accepted `start` until the engine returns to idle. Register loads while busy have no effect.
- R13: After reset, `busy`, `irq`, `bus_rd`, `bus_wr`, `match_flag` and `end_flag` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register load strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 16 | Register load data |
| start | input | 1 | Start a run or a single byte |
| bus_rd | output | 1 | Read request |
| bus_wr | output | 1 | Write request |
| bus_io | output | 1 | 1 = I/O space, 0 = memory |
| bus_addr | output | AW | Access address |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data |
| bus_ready | input | 1 | Access completes this cycle |
| busy | output | 1 | Engine running |
| match_flag | output | 1 | Search hit seen |
| end_flag | output | 1 | Block length reached |
| irq | output | 1 | Interrupt request |
| irq_vec | output | 8 | Interrupt vector |

## Verification
The transfer is swept over both directions, the three source stepping modes and lengths 1 to 4. Each sweep point alternates between a ready that always accepts and one that stalls two of every three cycles. This separates port selection, stepping sign, first-byte handling and the L+1 count, and it also exercises the bus hold rule. Searches are run unmasked with a pattern that first matches at byte 5, and masked so that only the low nibble decides. These show the stop point and show that the matching byte is still written. Single-step runs, a zero-length wrap run, an I/O destination, loads while busy and interrupt settings with and without the status code cover the remaining modes.

// File: rtl/dma2p_pkg.sv
package dma2p_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_STEP  = 3'd1,
    S_READ  = 3'd2,
    S_CMP   = 3'd3,
    S_WRITE = 3'd4,
    S_COUNT = 3'd5
  } dma_state_e;

  localparam logic [2:0] SEL_CTRL   = 3'd0;
  localparam logic [2:0] SEL_A_ADDR = 3'd1;
  localparam logic [2:0] SEL_A_MODE = 3'd2;
  localparam logic [2:0] SEL_B_ADDR = 3'd3;
  localparam logic [2:0] SEL_B_MODE = 3'd4;
  localparam logic [2:0] SEL_LEN    = 3'd5;
  localparam logic [2:0] SEL_MATCH  = 3'd6;
  localparam logic [2:0] SEL_IRQ    = 3'd7;

  localparam int CTL_WR    = 0;
  localparam int CTL_SRCH  = 1;
  localparam int CTL_A_SRC = 2;
  localparam int CTL_CONT  = 3;

  localparam int PM_IO  = 3;
  localparam int PM_UP  = 4;
  localparam int PM_FIX = 5;

  localparam int IC_ON_MATCH = 8;
  localparam int IC_ON_END   = 9;
  localparam int IC_EN       = 10;
  localparam int IC_STATVEC  = 13;
endpackage

// File: rtl/dma2p_rst_sync.sv
module dma2p_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/dma2p_port.sv
module dma2p_port import dma2p_pkg::*; #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_addr,
  input  logic          ld_mode,
  input  logic [15:0]   wdata,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic          is_io,
  output logic          up,
  output logic          fixed
);
  logic [AW-1:0] addr_q, addr_d;
  logic [2:0]    mode_q, mode_d;   // {fixed, up, io}

  always_comb begin
    addr_d = addr_q;
    mode_d = mode_q;
    if (ld_mode) mode_d = {wdata[PM_FIX], wdata[PM_UP], wdata[PM_IO]};
    if (ld_addr) begin
      addr_d = AW'(wdata);
    end else if (step && !mode_q[2]) begin
      addr_d = mode_q[1] ? addr_q + 1'b1 : addr_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      mode_q <= '0;
    end else begin
      addr_q <= addr_d;
      mode_q <= mode_d;
    end
  end

  assign addr  = addr_q;
  assign is_io = mode_q[0];
  assign up    = mode_q[1];
  assign fixed = mode_q[2];

  // R4
  fixed_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && fixed && !ld_addr) |=> $stable(addr));

  // R4
  up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !fixed && up && !ld_addr) |=> (addr == AW'($past(addr) + 1'b1)));
endmodule

// File: rtl/dma2p_len.sv
module dma2p_len #(
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          ld_len,
  input  logic [15:0]   wdata,
  input  logic          inc,
  output logic [LW-1:0] cnt,
  output logic          last
);
  logic [LW-1:0] len_q, len_d;
  logic [LW-1:0] cnt_q, cnt_d;

  always_comb begin
    len_d = ld_len ? LW'(wdata) : len_q;
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
      cnt_q <= '0;
    end else begin
      len_q <= len_d;
      cnt_q <= cnt_d;
    end
  end

  // the byte being counted is the last one if the counter wraps,
  // or if a nonzero length is already reached by the old count
  assign last = (&cnt_q) || ((len_q != '0) && (cnt_q >= len_q));
  assign cnt  = cnt_q;

  // R6
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && (&cnt)) |=> (cnt == '0));
endmodule

// File: rtl/dma2p_vec.sv
module dma2p_vec (
  input  logic [7:0] base,
  input  logic       stat_en,
  input  logic       hit_match,
  input  logic       hit_end,
  output logic [7:0] vec
);
  always_comb begin
    if (stat_en && hit_match)    vec = {base[7:3], 2'b01, base[0]};
    else if (stat_en && hit_end) vec = {base[7:3], 2'b10, base[0]};
    else                         vec = base;
  end

  // R11
  always_comb begin
    vec_code_chk: assert (!(stat_en && (hit_match || hit_end)) || (vec[2:1] != 2'b00));
  end
endmodule

// File: rtl/dma2p_engine.sv
module dma2p_engine import dma2p_pkg::*; #(
  parameter int AW       = 16,
  parameter int LW       = 16,
  parameter int BYTE_CYC = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [15:0]   cfg_wdata,
  input  logic          start,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic          bus_io,
  output logic [AW-1:0] bus_addr,
  output logic [7:0]    bus_wdata,
  input  logic [7:0]    bus_rdata,
  input  logic          bus_ready,
  output logic          busy,
  output logic          match_flag,
  output logic          end_flag,
  output logic          irq,
  output logic [7:0]    irq_vec
);
  localparam int             PW        = $clog2(BYTE_CYC + 1);
  localparam logic [PW-1:0]  PACE_LAST = PW'(BYTE_CYC - 1);

  logic rst_ns;

  dma_state_e    state_q, state_d;
  logic [PW-1:0] pace_q, pace_d, pace_nx;
  logic [3:0]    ctl_q, ctl_d;
  logic [7:0]    mval_q, mval_d, mask_q, mask_d;
  logic [7:0]    ivec_q, ivec_d;
  logic [3:0]    ictl_q, ictl_d;   // {statvec, enable, on_end, on_match}
  logic [7:0]    data_q, data_d;
  logic          first_q, first_d;
  logic          match_q, match_d;
  logic          end_q, end_d;
  logic          irq_q, irq_d;

  logic          cfg_ok, start_ok, clr_run, step_both;
  logic          pace_done, cnt_inc, stop, byte_hit, last;
  logic [LW-1:0] cnt;
  logic [AW-1:0] a_addr, b_addr, src_addr, dst_addr;
  logic          a_io, b_io, src_io, dst_io;
  logic          a_up, b_up, a_fix, b_fix;

  dma2p_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_ns)
  );

  assign cfg_ok    = cfg_we && (state_q == S_IDLE);
  assign start_ok  = start && !cfg_we && (state_q == S_IDLE) && !match_q && !end_q;
  assign clr_run   = cfg_ok && (cfg_sel == SEL_CTRL);
  assign step_both = (state_q == S_STEP) && !first_q;

  dma2p_port #(.AW(AW)) u_port_a (
    .clk(clk), .rst_n(rst_ns),
    .ld_addr(cfg_ok && (cfg_sel == SEL_A_ADDR)),
    .ld_mode(cfg_ok && (cfg_sel == SEL_A_MODE)),
    .wdata(cfg_wdata), .step(step_both),
    .addr(a_addr), .is_io(a_io), .up(a_up), .fixed(a_fix)
  );

  dma2p_port #(.AW(AW)) u_port_b (
    .clk(clk), .rst_n(rst_ns),
    .ld_addr(cfg_ok && (cfg_sel == SEL_B_ADDR)),
    .ld_mode(cfg_ok && (cfg_sel == SEL_B_MODE)),
    .wdata(cfg_wdata), .step(step_both),
    .addr(b_addr), .is_io(b_io), .up(b_up), .fixed(b_fix)
  );

  dma2p_len #(.LW(LW)) u_len (
    .clk(clk), .rst_n(rst_ns), .clr(clr_run),
    .ld_len(cfg_ok && (cfg_sel == SEL_LEN)),
    .wdata(cfg_wdata), .inc(cnt_inc), .cnt(cnt), .last(last)
  );

  dma2p_vec u_vec (
    .base(ivec_q), .stat_en(ictl_q[3]),
    .hit_match(match_q), .hit_end(end_q), .vec(irq_vec)
  );

  // port role selection
  assign src_addr = ctl_q[CTL_A_SRC] ? a_addr : b_addr;
  assign src_io   = ctl_q[CTL_A_SRC] ? a_io   : b_io;
  assign dst_addr = ctl_q[CTL_A_SRC] ? b_addr : a_addr;
  assign dst_io   = ctl_q[CTL_A_SRC] ? b_io   : a_io;

  assign pace_nx   = (pace_q == PACE_LAST) ? pace_q : pace_q + 1'b1;
  assign pace_done = (pace_q == PACE_LAST);
  assign cnt_inc   = (state_q == S_COUNT) && pace_done;
  assign stop      = match_q || last;
  assign byte_hit  = ((data_q ^ mval_q) & ~mask_q) == 8'h00;

  // bus outputs come straight from registered state, so they hold while waiting
  always_comb begin
    bus_rd    = (state_q == S_READ);
    bus_wr    = (state_q == S_WRITE) && ctl_q[CTL_WR];
    bus_io    = 1'b0;
    bus_addr  = '0;
    if (bus_rd) begin
      bus_io   = src_io;
      bus_addr = src_addr;
    end else if (bus_wr) begin
      bus_io   = dst_io;
      bus_addr = dst_addr;
    end
    bus_wdata = data_q;
  end

  always_comb begin
    state_d = state_q;
    pace_d  = pace_q;
    ctl_d   = ctl_q;
    mval_d  = mval_q;
    mask_d  = mask_q;
    ivec_d  = ivec_q;
    ictl_d  = ictl_q;
    data_d  = data_q;
    first_d = first_q;
    match_d = match_q;
    end_d   = end_q;
    irq_d   = irq_q;

    if (cfg_ok) begin
      case (cfg_sel)
        SEL_CTRL:  ctl_d = cfg_wdata[3:0];
        SEL_MATCH: begin
          mval_d = cfg_wdata[7:0];
          mask_d = cfg_wdata[15:8];
        end
        SEL_IRQ: begin
          ivec_d = cfg_wdata[7:0];
          ictl_d = {cfg_wdata[IC_STATVEC], cfg_wdata[IC_EN],
                    cfg_wdata[IC_ON_END], cfg_wdata[IC_ON_MATCH]};
        end
        default: ;
      endcase
    end
    if (clr_run) begin
      first_d = 1'b1;
      match_d = 1'b0;
      end_d   = 1'b0;
      irq_d   = 1'b0;
    end

    case (state_q)
      S_IDLE: begin
        if (start_ok) state_d = S_STEP;
      end
      S_STEP: begin
        pace_d  = PW'(1);
        state_d = S_READ;
      end
      S_READ: begin
        pace_d = pace_nx;
        if (bus_ready) begin
          data_d  = bus_rdata;
          state_d = S_CMP;
        end
      end
      S_CMP: begin
        pace_d = pace_nx;
        if (ctl_q[CTL_SRCH] && byte_hit) match_d = 1'b1;
        state_d = S_WRITE;
      end
      S_WRITE: begin
        pace_d = pace_nx;
        if (!ctl_q[CTL_WR] || bus_ready) state_d = S_COUNT;
      end
      S_COUNT: begin
        pace_d = pace_nx;
        if (pace_done) begin
          first_d = 1'b0;
          end_d   = end_q | last;
          if (stop && ictl_q[2] &&
              ((match_q && ictl_q[0]) || (last && ictl_q[1])))
            irq_d = 1'b1;
          state_d = (stop || !ctl_q[CTL_CONT]) ? S_IDLE : S_STEP;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      state_q <= S_IDLE;
      pace_q  <= '0;
      ctl_q   <= '0;
      mval_q  <= '0;
      mask_q  <= '0;
      ivec_q  <= '0;
      ictl_q  <= '0;
      data_q  <= '0;
      first_q <= 1'b1;
      match_q <= 1'b0;
      end_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pace_q  <= pace_d;
      ctl_q   <= ctl_d;
      mval_q  <= mval_d;
      mask_q  <= mask_d;
      ivec_q  <= ivec_d;
      ictl_q  <= ictl_d;
      data_q  <= data_d;
      first_q <= first_d;
      match_q <= match_d;
      end_q   <= end_d;
      irq_q   <= irq_d;
    end
  end

  assign busy       = (state_q != S_IDLE);
  assign match_flag = match_q;
  assign end_flag   = end_q;
  assign irq        = irq_q;

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (bus_rd && !bus_ready) |=> (bus_rd && $stable(bus_addr) && $stable(bus_io)));

  // R9
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (bus_wr && !bus_ready) |=> (bus_wr && $stable(bus_addr) && $stable(bus_io) && $stable(bus_wdata)));

  // R10
  irq_at_stop_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(irq) |-> $fell(busy));

  // R6
  end_at_stop_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(end_flag) |-> $fell(busy));

  // R3
  match_stop_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (match_flag && cnt_inc) |=> !busy);
endmodule

// File: tb/sim_dma2p_engine.sv
module sim_dma2p_engine;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = 3'd0;
  logic [15:0] cfg_wdata = 16'h0;
  logic        start = 1'b0;
  logic        bus_rd, bus_wr, bus_io;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata, bus_rdata;
  logic        bus_ready = 1'b1;
  logic        busy, match_flag, end_flag, irq;
  logic [7:0]  irq_vec;

  int n_chk = 0, n_fail = 0;
  int cyc = 0, rd_tot = 0, wr_tot = 0, viol = 0, holds = 0;
  int rmode = 0;
  logic [15:0] rl_addr [512];
  int          rl_cyc  [512];
  logic [15:0] wl_addr [512];
  logic [7:0]  wl_data [512];
  logic        wl_io   [512];
  logic        pend = 1'b0;
  logic        pend_wr = 1'b0;
  logic [15:0] pend_addr = '0;
  logic        pend_io = 1'b0;
  logic [7:0]  pend_data = '0;

  always #2.5 clk = ~clk;

  dma2p_engine #(.AW(16), .LW(8), .BYTE_CYC(6)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .start(start), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_io(bus_io), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready), .busy(busy),
    .match_flag(match_flag), .end_flag(end_flag), .irq(irq), .irq_vec(irq_vec)
  );

  function automatic logic [7:0] fmem(input logic [7:0] a);
    return a * 8'd7 + 8'd3;
  endfunction

  assign bus_rdata = bus_io ? (bus_addr[7:0] ^ 8'h5A) : fmem(bus_addr[7:0]);

  always @(negedge clk) bus_ready <= (rmode == 0) ? 1'b1 : ((cyc % 3) == 2);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (bus_rd && bus_ready) begin
      rl_addr[rd_tot % 512] <= bus_addr;
      rl_cyc[rd_tot % 512]  <= cyc;
      rd_tot <= rd_tot + 1;
    end
    if (bus_wr && bus_ready) begin
      wl_addr[wr_tot % 512] <= bus_addr;
      wl_data[wr_tot % 512] <= bus_wdata;
      wl_io[wr_tot % 512]   <= bus_io;
      wr_tot <= wr_tot + 1;
    end
    if (pend) begin
      holds <= holds + 1;
      if ((pend_wr ? !bus_wr : !bus_rd) || bus_addr != pend_addr || bus_io != pend_io ||
          (pend_wr && bus_wdata != pend_data))
        viol <= viol + 1;
    end
    pend      <= (bus_rd || bus_wr) && !bus_ready;
    pend_wr   <= bus_wr;
    pend_addr <= bus_addr;
    pend_io   <= bus_io;
    pend_data <= bus_wdata;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic cfg(input logic [2:0] sel, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic setup(input int ctrl, input int aa, input int am, input int ba,
                       input int bm, input int len, input int mword, input int iword);
    cfg(3'd1, 16'(aa)); cfg(3'd2, 16'(am));
    cfg(3'd3, 16'(ba)); cfg(3'd4, 16'(bm));
    cfg(3'd5, 16'(len)); cfg(3'd6, 16'(mword));
    cfg(3'd7, 16'(iword)); cfg(3'd0, 16'(ctrl));
  endtask

  task automatic run(input string req);
    int t;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    t = 0;
    while (busy && t < 4000) begin @(negedge clk); t++; end
    @(negedge clk);
    if (t >= 4000) chk(1'b0, req, t, 4000);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int r0, w0, bad;
    repeat (3) @(negedge clk);
    // R13 reset state
    chk(!busy && !irq && !bus_rd && !bus_wr && !match_flag && !end_flag, "R13",
        {busy, irq, bus_rd, bus_wr, match_flag, end_flag}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !bus_rd && !bus_wr, "R13", {busy, bus_rd, bus_wr}, 0);

    // sweep: direction x source stepping x length (R1 R4 R5 R6 R10 R11)
    for (int d = 0; d < 2; d++) begin
      for (int m = 0; m < 3; m++) begin
        for (int L = 1; L <= 4; L++) begin
          int stp = (m == 0) ? 1 : ((m == 1) ? -1 : 0);
          int fl  = (m == 0) ? 'h10 : ((m == 1) ? 'h00 : 'h20);
          rmode = L % 2;
          if (d == 1) setup('hD, 'h40, fl, 'hA0, 'h10, L, 0, 'h2681);
          else        setup('h9, 'hA0, 'h10, 'h40, fl, L, 0, 'h2681);
          r0 = rd_tot; w0 = wr_tot;
          run("R6");
          bad = 0;
          for (int k = 0; k <= L; k++) begin
            if (wl_addr[(w0 + k) % 512] != 16'(32'hA0 + k) || wl_io[(w0 + k) % 512] ||
                wl_data[(w0 + k) % 512] != fmem(8'(32'h40 + stp * k)))
              bad++;
          end
          chk(bad == 0, "R1", bad, 0);
          chk(rd_tot - r0 == L + 1 && wr_tot - w0 == L + 1 && end_flag, "R6", rd_tot - r0, L + 1);
          chk(rl_addr[r0 % 512] == 16'h0040, "R5", int'(rl_addr[r0 % 512]), 'h40);
          chk(rl_addr[(r0 + 1) % 512] == 16'(32'h40 + stp), "R4",
              int'(rl_addr[(r0 + 1) % 512]), 32'h40 + stp);
          chk(irq == 1'b1, "R10", irq, 1);
          chk(irq_vec == 8'h85, "R11", irq_vec, 'h85);
        end
      end
    end
    rmode = 0;
    chk(viol == 0 && holds > 0, "R9", viol, 0);

    // I/O destination, fixed; end without raise-on-end (R4 R10)
    setup('hD, 'h20, 'h10, 'h33, 'h28, 2, 0, 'h0500);
    w0 = wr_tot;
    run("R4");
    chk(wr_tot - w0 == 3 && wl_io[(w0 + 2) % 512] && wl_addr[(w0 + 2) % 512] == 16'h33 &&
        wl_data[(w0 + 2) % 512] == fmem(8'h22), "R4", int'(wl_data[(w0 + 2) % 512]), fmem(8'h22));
    chk(end_flag && !irq, "R10", irq, 0);

    // I/O source read (R4)
    setup('h9, 'h60, 'h10, 'h70, 'h18, 0, 0, 0);
    cfg(3'd5, 16'd1);
    w0 = wr_tot;
    run("R4");
    chk(wl_data[w0 % 512] == (8'h70 ^ 8'h5A) && wl_data[(w0 + 1) % 512] == (8'h71 ^ 8'h5A),
        "R4", int'(wl_data[(w0 + 1) % 512]), 8'h71 ^ 8'h5A);

    // search only, unmasked: first hit at byte 5 (R2 R3 R10 R11)
    setup('hE, 'h00, 'h10, 'h80, 'h10, 50, fmem(8'd5), 'h25F0);
    r0 = rd_tot; w0 = wr_tot;
    run("R3");
    chk(rd_tot - r0 == 6 && match_flag && !end_flag, "R3", rd_tot - r0, 6);
    chk(wr_tot - w0 == 0, "R2", wr_tot - w0, 0);
    chk(irq && irq_vec == 8'hF2, "R11", irq_vec, 'hF2);

    // masked search with transfer: low nibble 0xA first at byte 1 (R3 R11)
    setup('hF, 'h00, 'h10, 'h80, 'h10, 50, 'hF00A, 'h055E);
    r0 = rd_tot; w0 = wr_tot;
    run("R3");
    chk(rd_tot - r0 == 2 && wr_tot - w0 == 2 && wl_data[(w0 + 1) % 512] == fmem(8'd1) && match_flag,
        "R3", rd_tot - r0, 2);
    chk(irq && irq_vec == 8'h5E, "R11", irq_vec, 'h5E);

    // single-step mode (R7 R5)
    setup('h5, 'h10, 'h10, 'h90, 'h10, 3, 0, 0);
    r0 = rd_tot;
    run("R7");
    chk(rd_tot - r0 == 1 && !busy && !end_flag, "R7", rd_tot - r0, 1);
    run("R7");
    chk(rl_addr[(r0 + 1) % 512] == 16'h11, "R5", int'(rl_addr[(r0 + 1) % 512]), 'h11);
    run("R7");
    run("R7");
    chk(rd_tot - r0 == 4 && end_flag && rl_addr[(r0 + 3) % 512] == 16'h13, "R7", rd_tot - r0, 4);
    run("R7");
    chk(rd_tot - r0 == 4, "R7", rd_tot - r0, 4);

    // spacing with ready high (R8)
    setup('hD, 'h00, 'h10, 'h80, 'h10, 3, 0, 0);
    r0 = rd_tot;
    run("R8");
    bad = 0;
    for (int k = 0; k < 3; k++)
      if (rl_cyc[(r0 + k + 1) % 512] - rl_cyc[(r0 + k) % 512] != 6) bad++;
    chk(bad == 0, "R8", rl_cyc[(r0 + 1) % 512] - rl_cyc[r0 % 512], 6);

    // loads while busy are ignored (R12)
    setup('hD, 'h30, 'h10, 'h80, 'h10, 3, 0, 0);
    r0 = rd_tot;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy, "R12", busy, 1);
    cfg(3'd5, 16'd10);
    cfg(3'd1, 16'h0077);
    while (busy) @(negedge clk);
    @(negedge clk);
    chk(rd_tot - r0 == 4 && rl_addr[(r0 + 3) % 512] == 16'h33, "R12", rd_tot - r0, 4);

    // zero length: runs until the 8-bit counter wraps (R6)
    setup('h9, 'h50, 'h20, 'h60, 'h20, 0, 0, 0);
    r0 = rd_tot;
    run("R6");
    chk(rd_tot - r0 == 256 && end_flag, "R6", rd_tot - r0, 256);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule